// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block takes one fetched 32-bit instruction word and turns it into a series of issue phases for the execute stage. Each word holds one of two things. It may hold a single 30-bit long instruction. It may instead hold two 15-bit short instructions, a left one and a right one. A short pair can issue one slot after the other, in either order, or as a parallel pair. In a parallel pair, one slot may be a condition test that decides whether the other slot runs.

The execute stage reports back at each issue handshake. It says whether the issued slot moved the program counter, what a condition test returned, and whether the opcode lookup key missed. A moved program counter cancels the second slot of a sequential pair. A false test cancels the gated slot. A lookup miss raises a trap and drops whatever is left of the word. The block also keeps a cycle count and counts skipped and gated slots.

Top module: `slot_issue_seq`

## Requirements
- R1: After a synchronous active-low reset, `word_ready` is 1, `iss_valid`, `done` and `trap` are 0, and all four counters read 0.
- R2: Bits 31:30 equal to 00 mark a long word. It issues once with `iss_slot`=0, `iss_long`=1, `iss_phase`=0 and `iss_payload`= word bits 29:0. `done` rises on that handshake.
- R3: Bits 31:30 equal to 01 issue the right slot (bits 14:0, `iss_slot`=1) first and then the left slot (bits 29:15, `iss_slot`=0). Code 10 issues left first and then right. The first phase carries `iss_phase`=1 and the second carries 2. A short payload is its 15 bits with the upper bits set to zero.
- R4: In a sequential pair, `pc_changed`=1 on the first handshake cancels the second slot, ends the word and adds 1 to `cnt_skip`. `pc_changed` has no effect in any other phase.
- R5: `cnt_cycles` adds 1 for every accepted word, and 1 more when the second slot of a sequential pair issues.
- R6: Code 11 with `test_only_l`=1 issues the left slot first with `iss_phase`=3. If `cond_true`=1 on that handshake, `cnt_cond_true` adds 1 and the right slot issues with `iss_phase`=4. Otherwise `cnt_cond_false` adds 1 and the word ends. `cond_true` is ignored in every other phase.
- R7: Code 11 with only `test_only_r`=1 reverses R6: the right slot is the test and it gates the left slot. When both flags are set, the left slot is the test.
- R8: Code 11 with neither flag set issues left and then right, both with `iss_phase`=5.
- R9: `iss_key` is word bits 29:24 for a long word, and bits 14:9 of the issued 15-bit slot for a short one.
- R10: `key_miss`=1 on a handshake pulses `trap` and `done` together, issues no further slot of the word, and counts no skip and no condition event for that phase.
- R11: While `iss_valid`=1 and `iss_ready`=0, the issue outputs hold steady. `word_ready` and `iss_valid` are never 1 together, and a new word is accepted only after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Fetched word offered |
| word_ready | output | 1 | Sequencer idle and able to take a word |
| word_in | input | 32 | Fetched instruction word |
| test_only_l | input | 1 | Left slot is a condition-test-only opcode |
| test_only_r | input | 1 | Right slot is a condition-test-only opcode |
| iss_valid | output | 1 | Issue phase offered to execute |
| iss_ready | input | 1 | Execute takes the phase |
| iss_slot | output | 1 | 0 left or long, 1 right |
| iss_long | output | 1 | Payload is a long instruction |
| iss_phase | output | 3 | Phase tag (0 long, 1/2 sequential, 3 test, 4 gated, 5 parallel) |
| iss_payload | output | 30 | Instruction bits |
| iss_key | output | 6 | Opcode lookup key |
| pc_changed | input | 1 | Issued slot redirected the PC |
| cond_true | input | 1 | Result of the condition test |
| key_miss | input | 1 | Opcode lookup missed |
| done | output | 1 | Word fully retired on this handshake |
| trap | output | 1 | Illegal-instruction trap |
| cnt_cycles | output | 16 | Cycle counter |
| cnt_skip | output | 16 | Second slots cancelled by a branch |
| cnt_cond_true | output | 16 | Gated slots that ran |
| cnt_cond_false | output | 16 | Gated slots that were dropped |

## Verification
The bench tries every combination of the four format codes, both test-only flags, `pc_changed`, `cond_true` and three trap points (none, first handshake, second handshake). It also inserts back-pressure stalls on every third word. This sweep separates the two sequential orders from each other and from plain parallel issue. It shows that feedback signals acting in one phase are ignored in the others, that a trap takes priority over a skip or a condition count, and that the both-flags case resolves to a left-side test. The payloads come from a hash of the sweep index, so key and payload extraction is checked on varied bit patterns.

// File: rtl/slot_issue_pkg.sv
// Package: shared encodings for the dual-slot issue sequencer.
// Assumes: the format code occupies the two top bits of the word.
package slot_issue_pkg;

    typedef enum logic [1:0] {
        FMT_LONG   = 2'd0,
        FMT_RFIRST = 2'd1,
        FMT_LFIRST = 2'd2,
        FMT_PAIR   = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        PH_LONG  = 3'd0,
        PH_SEQ_A = 3'd1,
        PH_SEQ_B = 3'd2,
        PH_CTEST = 3'd3,
        PH_CEXEC = 3'd4,
        PH_PAR   = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } st_e;

    localparam int EV_CYCLE = 0;
    localparam int EV_SKIP  = 1;
    localparam int EV_CTRUE = 2;
    localparam int EV_CFALS = 3;
    localparam int EV_NUM   = 4;

endpackage

// File: rtl/issue_plan.sv
// Module: issue_plan
// Works out, from the format code and the two test-only flags, which slot
// goes first and which issue mode applies. Purely combinational.
// Assumes: when both slots are test-only, the left one is the test.
module issue_plan
    import slot_issue_pkg::*;
(
    input  fmt_e fmt,
    input  logic test_l,
    input  logic test_r,
    output logic is_long,
    output logic is_seq,
    output logic is_gated,
    output logic first_right
);
    // Resolve the issue mode and the order of the two slots.
    always_comb begin
        is_long     = (fmt == FMT_LONG);
        is_seq      = (fmt == FMT_RFIRST) || (fmt == FMT_LFIRST);
        is_gated    = (fmt == FMT_PAIR) && (test_l || test_r);
        first_right = 1'b0;
        case (fmt)
            FMT_RFIRST: first_right = 1'b1;
            FMT_LFIRST: first_right = 1'b0;
            FMT_PAIR:   first_right = !test_l && test_r;
            default:    first_right = 1'b0;
        endcase
    end
endmodule

// File: rtl/issue_slot_mux.sv
// Module: issue_slot_mux
// Picks the payload and opcode lookup key for the slot being issued.
// Assumes: the word is laid out as {fmt, left, right}, with equal-width
// short slots and the key at the top of each instruction.
module issue_slot_mux #(
    parameter int SHORT_W = 15,
    parameter int KEY_W   = 6,
    localparam int LONG_W = 2 * SHORT_W,
    localparam int WORD_W = LONG_W + 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic              is_long,
    input  logic              sel_right,
    output logic [LONG_W-1:0] payload,
    output logic [KEY_W-1:0]  key
);
    logic [SHORT_W-1:0] left_slot;
    logic [SHORT_W-1:0] right_slot;
    logic [SHORT_W-1:0] short_sel;

    // Split the word into its two short slots.
    always_comb begin
        left_slot  = word[LONG_W-1:SHORT_W];
        right_slot = word[SHORT_W-1:0];
        short_sel  = sel_right ? right_slot : left_slot;
    end

    // Form the payload and the lookup key for long or short issue.
    always_comb begin
        if (is_long) begin
            payload = word[LONG_W-1:0];
            key     = word[LONG_W-1 -: KEY_W];
        end else begin
            payload = {{SHORT_W{1'b0}}, short_sel};
            key     = short_sel[SHORT_W-1 -: KEY_W];
        end
    end
endmodule

// File: rtl/issue_fsm.sv
// Module: issue_fsm
// Accepts a word, steps through at most two issue phases under a
// valid/ready handshake, applies cancellation by branch, by condition test
// and by trap, and raises the event strobes for the counters.
// Assumes: the feedback inputs are meaningful only on a handshake cycle.
module issue_fsm
    import slot_issue_pkg::*;
#(
    parameter int SHORT_W = 15,
    localparam int LONG_W = 2 * SHORT_W,
    localparam int WORD_W = LONG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_in,
    input  logic              test_only_l,
    input  logic              test_only_r,
    output logic [WORD_W-1:0] word_q,
    output logic              is_long,
    output logic              cur_right,
    output logic              iss_valid,
    input  logic              iss_ready,
    output phase_e            phase,
    input  logic              pc_changed,
    input  logic              cond_true,
    input  logic              key_miss,
    output logic              done,
    output logic              trap,
    output logic [EV_NUM-1:0] events
);
    st_e  state_q, state_d;
    logic tl_q, tr_q;
    logic is_seq, is_gated, first_right;
    logic hs, last, accept;

    issue_plan plan_i (
        .fmt         (fmt_e'(word_q[WORD_W-1 -: 2])),
        .test_l      (tl_q),
        .test_r      (tr_q),
        .is_long     (is_long),
        .is_seq      (is_seq),
        .is_gated    (is_gated),
        .first_right (first_right)
    );

    // Handshake, word acceptance and the active slot.
    always_comb begin
        word_ready = (state_q == ST_IDLE);
        iss_valid  = (state_q != ST_IDLE);
        accept     = word_valid && word_ready;
        hs         = iss_valid && iss_ready;
        cur_right  = (state_q == ST_SECOND) ? !first_right : first_right;
    end

    // Phase tag for the slot being offered.
    always_comb begin
        if (is_long)
            phase = PH_LONG;
        else if (is_seq)
            phase = (state_q == ST_SECOND) ? PH_SEQ_B : PH_SEQ_A;
        else if (is_gated)
            phase = (state_q == ST_SECOND) ? PH_CEXEC : PH_CTEST;
        else
            phase = PH_PAR;
    end

    // Decide whether this handshake retires the word.
    always_comb begin
        if (state_q == ST_FIRST)
            last = is_long || key_miss || (is_seq && pc_changed)
                   || (is_gated && !cond_true);
        else
            last = 1'b1;
        done = hs && last;
        trap = hs && key_miss;
    end

    // Event strobes for the counters.
    always_comb begin
        events = '0;
        events[EV_CYCLE] = accept || (hs && state_q == ST_SECOND && is_seq);
        events[EV_SKIP]  = hs && state_q == ST_FIRST && is_seq && pc_changed && !key_miss;
        events[EV_CTRUE] = hs && state_q == ST_FIRST && is_gated && cond_true && !key_miss;
        events[EV_CFALS] = hs && state_q == ST_FIRST && is_gated && !cond_true && !key_miss;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept) state_d = ST_FIRST;
            ST_FIRST:  if (hs) state_d = last ? ST_IDLE : ST_SECOND;
            ST_SECOND: if (hs) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            tl_q    <= 1'b0;
            tr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                word_q <= word_in;
                tl_q   <= test_only_l;
                tr_q   <= test_only_r;
            end
        end
    end
endmodule

// File: rtl/event_counters.sv
// Module: event_counters
// A bank of wrapping event counters, one per strobe bit.
// Assumes: each strobe is at most one count per clock.
module event_counters #(
    parameter int NUM   = 4,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        // One counter: clear on reset, add one on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[g] <= '0;
            else if (inc[g])
                cnt[g] <= cnt[g] + 1'b1;
        end
    end
endmodule

// File: rtl/slot_issue_seq.sv
// Module: slot_issue_seq (top)
// Dual-slot instruction issue sequencer: decodes the word format, issues
// long or short slots to execute, and keeps cycle and event counters.
// Assumes: opcode classification and lookup happen outside; their results
// arrive as test_only_l/test_only_r with the word and key_miss at issue.
module slot_issue_seq
    import slot_issue_pkg::*;
#(
    parameter int SHORT_W = 15,
    parameter int KEY_W   = 6,
    parameter int CNT_W   = 16,
    localparam int LONG_W = 2 * SHORT_W,
    localparam int WORD_W = LONG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_in,
    input  logic              test_only_l,
    input  logic              test_only_r,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic              iss_slot,
    output logic              iss_long,
    output logic [2:0]        iss_phase,
    output logic [LONG_W-1:0] iss_payload,
    output logic [KEY_W-1:0]  iss_key,
    input  logic              pc_changed,
    input  logic              cond_true,
    input  logic              key_miss,
    output logic              done,
    output logic              trap,
    output logic [CNT_W-1:0]  cnt_cycles,
    output logic [CNT_W-1:0]  cnt_skip,
    output logic [CNT_W-1:0]  cnt_cond_true,
    output logic [CNT_W-1:0]  cnt_cond_false
);
    logic [WORD_W-1:0]            word_q;
    logic                         is_long, cur_right;
    phase_e                       phase;
    logic [EV_NUM-1:0]            events;
    logic [EV_NUM-1:0][CNT_W-1:0] cnt;

    issue_fsm #(.SHORT_W(SHORT_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .word_ready  (word_ready),
        .word_in     (word_in),
        .test_only_l (test_only_l),
        .test_only_r (test_only_r),
        .word_q      (word_q),
        .is_long     (is_long),
        .cur_right   (cur_right),
        .iss_valid   (iss_valid),
        .iss_ready   (iss_ready),
        .phase       (phase),
        .pc_changed  (pc_changed),
        .cond_true   (cond_true),
        .key_miss    (key_miss),
        .done        (done),
        .trap        (trap),
        .events      (events)
    );

    issue_slot_mux #(.SHORT_W(SHORT_W), .KEY_W(KEY_W)) mux_i (
        .word      (word_q),
        .is_long   (is_long),
        .sel_right (cur_right),
        .payload   (iss_payload),
        .key       (iss_key)
    );

    event_counters #(.NUM(EV_NUM), .CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (events),
        .cnt   (cnt)
    );

    // Present the slot descriptor and counter values on the ports.
    always_comb begin
        iss_slot       = cur_right && !is_long;
        iss_long       = is_long;
        iss_phase      = phase;
        cnt_cycles     = cnt[EV_CYCLE];
        cnt_skip       = cnt[EV_SKIP];
        cnt_cond_true  = cnt[EV_CTRUE];
        cnt_cond_false = cnt[EV_CFALS];
    end
endmodule

// File: rtl/slot_issue_seq_chk.sv
// Module: slot_issue_seq_chk
// Protocol and sequencing properties for slot_issue_seq, bound to the top.
module slot_issue_seq_chk #(
    parameter int LONG_W = 30,
    parameter int KEY_W  = 6,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_ready,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              iss_slot,
    input logic [2:0]        iss_phase,
    input logic [LONG_W-1:0] iss_payload,
    input logic [KEY_W-1:0]  iss_key,
    input logic              pc_changed,
    input logic              cond_true,
    input logic              key_miss,
    input logic              done,
    input logic              trap,
    input logic [CNT_W-1:0]  cnt_skip,
    input logic [CNT_W-1:0]  cnt_cond_true
);
    assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !iss_ready |=> iss_valid && $stable(iss_payload)
            && $stable(iss_phase) && $stable(iss_slot) && $stable(iss_key));

    assert_ready_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_ready && iss_valid));

    assert_done_on_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> iss_valid && iss_ready);

    assert_trap_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !iss_valid && word_ready);

    assert_skip_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_skip != $past(cnt_skip)) |->
            $past(iss_valid && iss_ready && iss_phase == 3'd1 && pc_changed && !key_miss));

    assert_seq_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready && iss_phase == 3'd1 && !pc_changed && !key_miss) |=>
            iss_valid && iss_phase == 3'd2 && (iss_slot != $past(iss_slot)));

    assert_ctrue_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cond_true != $past(cnt_cond_true)) |->
            $past(iss_valid && iss_ready && iss_phase == 3'd3 && cond_true));
endmodule

bind slot_issue_seq slot_issue_seq_chk #(
    .LONG_W (LONG_W),
    .KEY_W  (KEY_W),
    .CNT_W  (CNT_W)
) chk_i (.*);

// File: tb/slot_issue_seq_tb.sv
`timescale 1ns/1ps
module slot_issue_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [31:0] word_in = '0;
    logic        test_only_l = 1'b0, test_only_r = 1'b0;
    logic        iss_valid, iss_ready = 1'b0;
    logic        iss_slot, iss_long;
    logic [2:0]  iss_phase;
    logic [29:0] iss_payload;
    logic [5:0]  iss_key;
    logic        pc_changed = 1'b0, cond_true = 1'b0, key_miss = 1'b0;
    logic        done, trap;
    logic [15:0] cnt_cycles, cnt_skip, cnt_cond_true, cnt_cond_false;

    int checks = 0, fails = 0;
    int e_cyc = 0, e_skip = 0, e_ct = 0, e_cf = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    slot_issue_seq dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_counters();
        chk(cnt_cycles == 16'(e_cyc), "R5", "cnt_cycles", 32'(cnt_cycles), 32'(e_cyc));
        chk(cnt_skip == 16'(e_skip), "R4", "cnt_skip", 32'(cnt_skip), 32'(e_skip));
        chk(cnt_cond_true == 16'(e_ct), "R6", "cnt_cond_true", 32'(cnt_cond_true), 32'(e_ct));
        chk(cnt_cond_false == 16'(e_cf), "R6", "cnt_cond_false", 32'(cnt_cond_false), 32'(e_cf));
    endtask

    task automatic run_word(input logic [31:0] w, input bit tl, input bit tr,
                            input bit pcch, input bit cnd, input int miss_at, input bit stall);
        logic [1:0]  fmt;
        logic [14:0] lft, rgt;
        bit          fr, seq, gated;
        int          n;
        logic        e_slot[2];
        logic [2:0]  e_ph[2];
        logic [29:0] e_pl[2];
        logic [5:0]  e_key[2];
        string       req;
        fmt = w[31:30];
        lft = w[29:15];
        rgt = w[14:0];
        seq = (fmt == 2'd1) || (fmt == 2'd2);
        gated = (fmt == 2'd3) && (tl || tr);
        fr = (fmt == 2'd1) || (fmt == 2'd3 && !tl && tr);
        req = (fmt == 2'd0) ? "R2" : seq ? "R3" : gated ? ((tr && !tl) ? "R7" : "R6") : "R8";
        e_cyc++;
        if (fmt == 2'd0) begin
            n = 1;
            e_slot[0] = 1'b0; e_ph[0] = 3'd0; e_pl[0] = w[29:0]; e_key[0] = w[29:24];
        end else begin
            e_slot[0] = fr;
            e_pl[0]   = {15'd0, fr ? rgt : lft};
            e_key[0]  = fr ? rgt[14:9] : lft[14:9];
            e_ph[0]   = seq ? 3'd1 : gated ? 3'd3 : 3'd5;
            e_slot[1] = !fr;
            e_pl[1]   = {15'd0, fr ? lft : rgt};
            e_key[1]  = fr ? lft[14:9] : rgt[14:9];
            e_ph[1]   = seq ? 3'd2 : gated ? 3'd4 : 3'd5;
            if (miss_at == 1) n = 1;
            else if (seq && pcch) begin n = 1; e_skip++; end
            else if (gated && !cnd) begin n = 1; e_cf++; end
            else begin
                n = 2;
                if (gated) e_ct++;
                if (seq) e_cyc++;
            end
        end
        @(negedge clk);
        chk(word_ready === 1'b1, "R11", "word_ready idle", 32'(word_ready), 1);
        word_valid = 1'b1; word_in = w; test_only_l = tl; test_only_r = tr;
        @(negedge clk);
        word_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            #1;
            if (stall) begin
                iss_ready = 1'b0;
                @(negedge clk);
                #1;
                chk(iss_valid === 1'b1, "R11", "valid held", 32'(iss_valid), 1);
                chk(iss_payload === e_pl[k], "R11", "payload held", 32'(iss_payload), 32'(e_pl[k]));
            end
            iss_ready = 1'b1;
            key_miss = (miss_at == k + 1);
            pc_changed = pcch;
            cond_true = cnd;
            #1;
            chk(iss_valid === 1'b1, req, "iss_valid", 32'(iss_valid), 1);
            chk(iss_slot === e_slot[k], req, "iss_slot", 32'(iss_slot), 32'(e_slot[k]));
            chk(iss_long === (fmt == 2'd0), req, "iss_long", 32'(iss_long), 32'(fmt == 2'd0));
            chk(iss_phase === e_ph[k], req, "iss_phase", 32'(iss_phase), 32'(e_ph[k]));
            chk(iss_payload === e_pl[k], req, "iss_payload", 32'(iss_payload), 32'(e_pl[k]));
            chk(iss_key === e_key[k], "R9", "iss_key", 32'(iss_key), 32'(e_key[k]));
            chk(done === (k == n - 1), req, "done", 32'(done), 32'(k == n - 1));
            chk(trap === (miss_at == k + 1), "R10", "trap", 32'(trap), 32'(miss_at == k + 1));
            @(negedge clk);
            iss_ready = 1'b0; key_miss = 1'b0; pc_changed = 1'b0; cond_true = 1'b0;
        end
        #1;
        chk(iss_valid === 1'b0, "R10", "no slot after retire", 32'(iss_valid), 0);
        chk_counters();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(word_ready === 1'b1, "R1", "word_ready", 32'(word_ready), 1);
        chk(iss_valid === 1'b0, "R1", "iss_valid", 32'(iss_valid), 0);
        chk(done === 1'b0 && trap === 1'b0, "R1", "done|trap", 32'({done, trap}), 0);
        chk_counters();
        idx = 0;
        for (int f = 0; f < 4; f++)
            for (int tl = 0; tl < 2; tl++)
                for (int tr = 0; tr < 2; tr++)
                    for (int pc = 0; pc < 2; pc++)
                        for (int cd = 0; cd < 2; cd++)
                            for (int m = 0; m < 3; m++) begin
                                logic [31:0] h;
                                h = 32'(idx + 1) * 32'h9E3779B1;
                                h = h ^ (h >> 13);
                                run_word({2'(f), h[29:0]}, bit'(tl), bit'(tr), bit'(pc),
                                         bit'(cd), m, (idx % 3) == 0);
                                idx++;
                            end
        // Corner payloads: all ones and all zeros in each format.
        for (int f = 0; f < 4; f++) begin
            run_word({2'(f), 30'h3FFFFFFF}, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0);
            run_word({2'(f), 30'h0}, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1'b1);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule